// File: doc/BRIEF.md
# Nine-Bit Multidrop Receive Filter

This block sits between a UART receive deserializer and the receive FIFO. Every received character arrives with a one-cycle valid strobe, eight data bits and a ninth bit. When ninth-bit mode is on, the block marks each character as a station address or as data. It can drop characters that are meant for other stations. Characters it accepts are handed to the FIFO as one-cycle push strobes, and an interrupt is raised when an address character is accepted.

A small register port holds three registers:
- **Mode register** (written at offset 6h). Bit 0 turns on ninth-bit mode. Bit 1 turns on automatic address filtering. Bit 3 selects the polarity of the ninth bit. A read at offset 6h returns the modem status input instead of the mode register.
- **Station address register** (offset 5h).
- **Feature register** (offset 2h). Bit 0 is the enhanced-feature enable, which filtering also needs.

Top module: `mdrop_rx_filter`

## Requirements
- R1: After reset, `push`, `overrun` and `irq` are 0, and reads of the station address (offset 5h) and the feature register (offset 2h) return 0. The mode register resets to 8'h08, which means ninth-bit mode is off and the polarity bit is 1.
- R2: While mode bit 0 is 0, every character with `rx_valid` high is pushed in the next cycle. `push_data` equals `rx_data`, `push_is_addr` is 0 and `irq` is not raised.
- R3: While mode bit 0 is 1, a character is an address exactly when `rx_bit9` equals mode bit 3. Otherwise it is data. `push_is_addr` carries this class with each push.
- R4: Filtering is active only when mode bit 0, mode bit 1 and feature register bit 0 are all 1. Otherwise every character is pushed.
- R5: While filtering is active, an address character equal to the station address register is pushed, and an address character that differs from it is dropped with no push and no overrun.
- R6: While filtering is active, data characters are pushed only when the most recent address seen in ninth-bit mode matched. Data characters are dropped after a non-matching address and also after reset, before any address has been seen.
- R7: `irq` rises in the cycle after an accepted address character in ninth-bit mode. It stays high until a cycle with `irq_ack` high and no new address event, and a new event in the same cycle as the acknowledge wins.
- R8: An accepted character that arrives while `rx_full` is 1 is not pushed. Instead `overrun` pulses for one cycle in the next cycle.
- R9: A read at offset 6h returns `msr_in`. Feature register bits 7:1 read as 0. All offsets other than 2h, 5h and 6h read as 0. Writes to mode bits 7:4 and bit 2 have no effect on filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| msr_in | input | 8 | Modem status value returned for reads at 6h |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received data bits |
| rx_bit9 | input | 1 | Received ninth bit |
| rx_full | input | 1 | Downstream FIFO full |
| push | output | 1 | One-cycle push of an accepted character |
| push_data | output | 8 | Pushed character |
| push_is_addr | output | 1 | Pushed character is an address |
| overrun | output | 1 | One-cycle pulse: accepted character lost to full |
| irq | output | 1 | Address interrupt level |
| irq_ack | input | 1 | Interrupt acknowledge pulse |

## Verification
The assertions assume that `rx_valid` and the register strobe each last one cycle. They also assume that `irq_ack` and `rx_full` are stable across a clock edge. The bench drives every input on the falling edge for exactly one cycle, so this assumption holds.

The random stimulus draws the data byte from the station address about half the time, so both matching and non-matching addresses occur often. Register writes are only issued between bursts of characters, so the mode is stable while characters are checked.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  // Register offsets; the mode offset is shared with modem status reads.
  localparam int OFF_FEAT = 2;
  localparam int OFF_STA  = 5;
  localparam int OFF_MODE = 6;

  typedef struct packed {
    logic [3:0] rsv_hi;
    logic       pol;
    logic       rsv_lo;
    logic       ame;
    logic       mde;
  } mode_t;

  localparam mode_t MODE_RST = '{rsv_hi: 4'h0, pol: 1'b1, rsv_lo: 1'b0, ame: 1'b0, mde: 1'b0};

  // Reserved bits are forced to zero on every write.
  function automatic mode_t mode_clean(input logic [7:0] w);
    mode_t m;
    m        = mode_t'(w);
    m.rsv_hi = 4'h0;
    m.rsv_lo = 1'b0;
    return m;
  endfunction

  // Address class: ninth bit equal to the polarity bit.
  function automatic logic char_is_addr(input logic bit9, input mode_t m);
    return m.mde && (bit9 == m.pol);
  endfunction

  function automatic logic filt_active(input mode_t m, input logic feat);
    return m.mde && m.ame && feat;
  endfunction
endpackage

// File: rtl/mdrop_regs.sv
module mdrop_regs
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] msr_in,
  output logic [DATA_W-1:0] reg_rdata,
  output mode_t             mode,
  output logic              feat_en,
  output logic [DATA_W-1:0] station
);
  localparam logic [ADDR_W-1:0] A_FEAT = ADDR_W'(OFF_FEAT);
  localparam logic [ADDR_W-1:0] A_STA  = ADDR_W'(OFF_STA);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);

  logic wr_mode, wr_sta, wr_feat;
  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_sta  = reg_wr && (reg_addr == A_STA);
  assign wr_feat = reg_wr && (reg_addr == A_FEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_RST;
      feat_en <= 1'b0;
      station <= '0;
    end else begin
      if (wr_mode) mode    <= mode_clean(reg_wdata[7:0]);
      if (wr_feat) feat_en <= reg_wdata[0];
      if (wr_sta)  station <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_FEAT:  reg_rdata = {{(DATA_W-1){1'b0}}, feat_en};
      A_STA:   reg_rdata = station;
      A_MODE:  reg_rdata = msr_in;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdrop_classify.sv
module mdrop_classify
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_bit9,
  input  mode_t             mode,
  input  logic              feat_en,
  input  logic [DATA_W-1:0] station,
  output logic              is_addr,
  output logic              filt_on,
  output logic              sta_match
);
  assign is_addr   = char_is_addr(rx_bit9, mode);
  assign filt_on   = filt_active(mode, feat_en);
  assign sta_match = (rx_data == station);
endmodule

// File: rtl/mdrop_gate.sv
module mdrop_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_full,
  input  logic              is_addr,
  input  logic              filt_on,
  input  logic              sta_match,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_is_addr,
  output logic              overrun,
  output logic              addr_hit,
  output logic              char_drop
);
  logic gate_open;  // last address seen in ninth-bit mode matched
  logic accept;
  logic take;

  assign accept    = !filt_on || (is_addr ? sta_match : gate_open);
  assign take      = rx_valid && accept;
  assign addr_hit  = take && is_addr;
  assign char_drop = rx_valid && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_open    <= 1'b0;
      push         <= 1'b0;
      overrun      <= 1'b0;
      push_data    <= '0;
      push_is_addr <= 1'b0;
    end else begin
      if (rx_valid && is_addr) gate_open <= sta_match;
      push    <= take && !rx_full;
      overrun <= take && rx_full;
      if (take) begin
        push_data    <= rx_data;
        push_is_addr <= is_addr;
      end
    end
  end
endmodule

// File: rtl/mdrop_irq.sv
module mdrop_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_hit,
  input  logic irq_ack,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= addr_hit || (irq && !irq_ack);
  end
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] msr_in,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_bit9,
  input  logic              rx_full,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_is_addr,
  output logic              overrun,
  output logic              irq,
  input  logic              irq_ack
);
  mode_t             mode;
  logic              feat_en;
  logic [DATA_W-1:0] station;
  logic              is_addr, filt_on, sta_match;
  logic              addr_hit, char_drop;
  logic              mde;

  assign mde = mode.mde;

  mdrop_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .msr_in(msr_in), .reg_rdata(reg_rdata),
    .mode(mode), .feat_en(feat_en), .station(station)
  );

  mdrop_classify #(.DATA_W(DATA_W)) u_cls (
    .rx_data(rx_data), .rx_bit9(rx_bit9), .mode(mode), .feat_en(feat_en),
    .station(station), .is_addr(is_addr), .filt_on(filt_on), .sta_match(sta_match)
  );

  mdrop_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_full(rx_full), .is_addr(is_addr), .filt_on(filt_on), .sta_match(sta_match),
    .push(push), .push_data(push_data), .push_is_addr(push_is_addr),
    .overrun(overrun), .addr_hit(addr_hit), .char_drop(char_drop)
  );

  mdrop_irq u_irq (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .irq_ack(irq_ack), .irq(irq)
  );
endmodule

// File: rtl/mdrop_rx_filter_chk.sv
module mdrop_rx_filter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              push,
  input logic [DATA_W-1:0] push_data,
  input logic              push_is_addr,
  input logic              overrun,
  input logic              irq,
  input logic              irq_ack,
  input logic              mde,
  input logic              addr_hit,
  input logic              char_drop
);
  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mde && !rx_full) |=> (push && !push_is_addr && push_data == $past(rx_data))); // R2
  AST_ADDR_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_is_addr) |-> $past(mde)); // R3
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    char_drop |=> (!push && !overrun)); // R5
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(rx_valid && !rx_full)); // R8
  AST_OVR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !push); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> irq); // R7
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(addr_hit)); // R7
endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_full(rx_full),
  .push(push), .push_data(push_data), .push_is_addr(push_is_addr), .overrun(overrun),
  .irq(irq), .irq_ack(irq_ack), .mde(mde), .addr_hit(addr_hit), .char_drop(char_drop)
);

// File: tb/mdrop_rx_filter_tb.sv
`timescale 1ns/1ps
module mdrop_rx_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] msr_in = 8'h00;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_bit9 = 1'b0;
  logic       rx_full = 1'b0;
  logic       push, push_is_addr, overrun, irq;
  logic [7:0] push_data;
  logic       irq_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  mdrop_rx_filter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msr_in(msr_in),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
    .push(push), .push_data(push_data), .push_is_addr(push_is_addr),
    .overrun(overrun), .irq(irq), .irq_ack(irq_ack)
  );

  // Reference state, updated from the requirements
  bit       m_nine, m_auto, m_pol, m_feat, m_last_ok;
  bit [7:0] m_sta;
  bit       e_push, e_ovr, e_flag, e_irq;
  bit [7:0] e_data;

  function automatic bit ref_addr(bit b9);            // R3
    return m_nine && !(b9 ^ m_pol);
  endfunction
  function automatic bit ref_keep(bit addr, bit [7:0] d); // R4 R5 R6
    if (!(m_nine && m_auto && m_feat)) return 1'b1;
    if (addr) return d == m_sta;
    return m_last_ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_nine <= 0; m_auto <= 0; m_pol <= 1; m_feat <= 0; m_sta <= 0; m_last_ok <= 0;
      e_push <= 0; e_ovr <= 0; e_flag <= 0; e_irq <= 0; e_data <= 0;
    end else begin
      bit a, k;
      a = ref_addr(rx_bit9);
      k = ref_keep(a, rx_data);
      if (reg_wr && reg_addr == 3'd6) begin
        m_nine <= reg_wdata[0]; m_auto <= reg_wdata[1]; m_pol <= reg_wdata[3];
      end
      if (reg_wr && reg_addr == 3'd2) m_feat <= reg_wdata[0];
      if (reg_wr && reg_addr == 3'd5) m_sta <= reg_wdata;
      if (rx_valid && a) m_last_ok <= (rx_data == m_sta);
      e_push <= rx_valid && k && !rx_full;
      e_ovr  <= rx_valid && k && rx_full;
      if (rx_valid && k) begin e_data <= rx_data; e_flag <= a; end
      if (rx_valid && k && a) e_irq <= 1'b1;
      else if (irq_ack) e_irq <= 1'b0;
    end
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(push == e_push, "push", int'(push), int'(e_push));
      if (e_push && push) begin
        check(push_data == e_data, "push_data", int'(push_data), int'(e_data));
        check(push_is_addr == e_flag, "push_is_addr", int'(push_is_addr), int'(e_flag));
      end
      check(overrun == e_ovr, "overrun", int'(overrun), int'(e_ovr));
      check(irq == e_irq, "irq", int'(irq), int'(e_irq));
    end
  end

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input bit [2:0] a, input bit [7:0] exp, input string t);
    @(negedge clk); reg_addr = a; #1;
    tag = t;
    check(reg_rdata == exp, "reg_rdata", int'(reg_rdata), int'(exp));
  endtask

  task automatic chr(input bit [7:0] d, input bit b9, input bit full);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_bit9 = b9; rx_full = full;
    @(negedge clk); rx_valid = 0; rx_full = 0;
  endtask

  task automatic rand_run(int n, int pfull, int pack);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = ($urandom % 3) != 0;
      rx_data  = ($urandom % 2) ? m_sta : 8'($urandom);
      rx_bit9  = 1'($urandom);
      rx_full  = ($urandom % 100) < pfull;
      irq_ack  = ($urandom % 100) < pack;
    end
    @(negedge clk); rx_valid = 0; rx_full = 0; irq_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    check(push == 0 && overrun == 0 && irq == 0, "outputs after reset",
          int'({push, overrun, irq}), 0);
    rd(3'd5, 8'h00, "R1");
    rd(3'd2, 8'h00, "R1");
    chk_en = 1;

    tag = "R2";                           // normal mode, both ninth bits
    chr(8'hA5, 1'b1, 1'b0);
    chr(8'h5A, 1'b0, 1'b0);
    rand_run(300, 0, 20);

    tag = "R3";                           // polarity 1 then 0, no filter
    wr(3'd6, 8'h09);
    chr(8'h11, 1'b1, 0); chr(8'h22, 1'b0, 0);
    rand_run(200, 0, 30);
    wr(3'd6, 8'h01);
    chr(8'h33, 1'b0, 0); chr(8'h44, 1'b1, 0);
    rand_run(200, 0, 30);

    tag = "R4";                           // auto bit set but feature off
    wr(3'd5, 8'h3C);
    wr(3'd6, 8'h0B);
    chr(8'h10, 1'b1, 0); chr(8'h77, 1'b0, 0);
    rand_run(200, 0, 30);

    tag = "R6";                           // feature on; gate still closed
    wr(3'd2, 8'h01);
    chr(8'h12, 1'b1, 0);                  // mismatch address
    chr(8'h99, 1'b0, 0);
    tag = "R5";
    chr(8'h3C, 1'b1, 0);                  // matching address
    tag = "R6";
    chr(8'h55, 1'b0, 0);
    chr(8'h40, 1'b1, 0);
    chr(8'h66, 1'b0, 0);
    tag = "R5";
    rand_run(600, 0, 25);

    tag = "R7";                           // ack collides with new address
    chr(8'h3C, 1'b1, 0);
    @(negedge clk); rx_valid = 1; rx_data = 8'h3C; rx_bit9 = 1; irq_ack = 1;
    @(negedge clk); rx_valid = 0; irq_ack = 0;
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    rand_run(300, 0, 10);

    tag = "R8";
    chr(8'h3C, 1'b1, 1'b1);
    rand_run(400, 30, 20);

    tag = "R9";
    msr_in = 8'hC3;
    rd(3'd6, 8'hC3, "R9");
    rd(3'd2, 8'h01, "R9");
    wr(3'd2, 8'hFE);
    rd(3'd2, 8'h00, "R9");
    rd(3'd5, 8'h3C, "R9");
    rd(3'd0, 8'h00, "R9");
    rd(3'd7, 8'h00, "R9");
    wr(3'd2, 8'h01);
    wr(3'd6, 8'hF7);                      // reserved bits set, filter on, pol 0
    chr(8'h3C, 1'b0, 0); chr(8'h21, 1'b0, 0); chr(8'h22, 1'b1, 0);
    rand_run(300, 10, 20);

    @(negedge clk);
    chk_en = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule